// File: doc/BRIEF.md
# Polled Priority Event Dispatcher

This block collects hardware event pulses, for example a serial transmitter whose holding register has emptied or a serial receiver whose register has filled. It keeps one pending flag per task slot. Nothing is pre-empted. A pending request has no effect on the processor until the program issues an explicit dispatch command. That is normally done at a point in the code where buffers and registers are free to serve the handlers.

On a dispatch strobe the block picks one pending slot: the one whose programmed priority number is lowest. It returns that slot's handler vector one cycle later, with a valid flag and the slot index, and clears that slot's pending flag on the same edge. If no slot is pending, the block returns a programmable default vector with valid low. Software can read the pending and overrun flags and clear any of them with a write-one-to-clear mask. Each slot's priority and vector are written through a small configuration port.

Top module: `evsched_top`

## Requirements
- R1: After reset the pending vector, the overrun vector, `disp_ack` and `disp_valid` are all zero. Slot i has priority i and vector i, and the default vector is all ones (0x3FF at the default width).
- R2: A one-cycle pulse on `ev_pulse[i]` sets `pend[i]`, which reads as 1 from the cycle after the pulse.
- R3: Without a dispatch strobe, events never disturb dispatch: `disp_ack` stays low the next cycle, and `disp_vec`, `disp_valid` and `disp_task` hold their values.
- R4: A dispatch strobe in cycle t gives, in cycle t+1, `disp_ack`=1, `disp_valid`=1, `disp_vec` equal to the vector of the winner and `disp_task` equal to its index. The winner is the pending slot with the numerically lowest priority value (0 is the most urgent).
- R5: The winner's pending flag clears on the dispatch edge. Every other pending flag is unchanged.
- R6: A pulse for the winning slot in the dispatch cycle leaves its flag set, and that pulse does not set the slot's overrun bit.
- R7: A dispatch with no flag pending gives `disp_ack`=1, `disp_valid`=0, `disp_task`=0 and `disp_vec` equal to the default vector.
- R8: A pulse on a slot whose flag is already set, and which is not being dispatched in that cycle, merges into the one request and sets that slot's sticky `ovr` bit. Only the clear mask resets the bit; a dispatch does not.
- R9: A 1 in `clr_mask[i]` clears `pend[i]` and `ovr[i]` on the next edge. A pulse on the same slot in the same cycle takes precedence, and the flag stays set.
- R10: With `cfg_we` high, slot `cfg_idx` takes `cfg_prio` and `cfg_vec`. With `dflt_we` high, the default vector takes `dflt_vec`. Both take effect for a dispatch issued in the following cycle.
- R11: If two pending slots hold the same priority, the lower slot index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | N | One-cycle event pulses, one per slot |
| clr_mask | input | N | Write-one-to-clear for pending and overrun flags |
| cfg_we | input | 1 | Slot configuration write enable |
| cfg_idx | input | IDX_W | Slot being configured |
| cfg_prio | input | IDX_W | Priority for that slot, 0 most urgent |
| cfg_vec | input | VEC_W | Handler vector for that slot |
| dflt_we | input | 1 | Default vector write enable |
| dflt_vec | input | VEC_W | Vector returned when nothing is pending |
| dispatch | input | 1 | Dispatch command strobe |
| disp_ack | output | 1 | Dispatch result present (cycle after strobe) |
| disp_valid | output | 1 | A pending slot was selected |
| disp_vec | output | VEC_W | Selected handler vector or default |
| disp_task | output | IDX_W | Selected slot index (0 when none) |
| pend | output | N | Pending flag readback |
| ovr | output | N | Sticky overrun readback |

## Verification
Every result of this block comes from exactly one register stage. Pending and overrun flags, dispatch outputs and configuration updates all show the effect of inputs driven in cycle t during cycle t+1. The bench drives inputs after the falling edge, lets one rising edge pass, and samples at the next falling edge. Results are therefore read exactly one edge after their cause and never in the same cycle. The main sweep loads every one of the 256 pending patterns under two priority permutations. It recomputes the expected winner by scanning priority levels in order, not slots in order.

// File: rtl/evsched_pkg.sv
package evsched_pkg;
  localparam int unsigned DEF_TASKS = 8;
  localparam int unsigned DEF_VEC_W = 10;

  // Candidate replaces the current best only when strictly more urgent,
  // so on equal priority the earlier (lower) index is kept.
  function automatic logic more_urgent(logic have_best, int unsigned cand_prio,
                                       int unsigned best_prio);
    return !have_best || (cand_prio < best_prio);
  endfunction
endpackage

// File: rtl/evsched_cfg.sv
module evsched_cfg #(
  parameter int unsigned N     = 8,
  parameter int unsigned VEC_W = 10,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [IDX_W-1:0]   cfg_prio,
  input  logic [VEC_W-1:0]   cfg_vec,
  input  logic               dflt_we,
  input  logic [VEC_W-1:0]   dflt_vec,
  output logic [N*IDX_W-1:0] prio_flat,
  output logic [N*VEC_W-1:0] vec_flat,
  output logic [VEC_W-1:0]   dflt_q
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic hit;
    assign hit = cfg_we && (cfg_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_flat[g*IDX_W +: IDX_W] <= IDX_W'(g);
        vec_flat[g*VEC_W +: VEC_W]  <= VEC_W'(g);
      end else if (hit) begin
        prio_flat[g*IDX_W +: IDX_W] <= cfg_prio;
        vec_flat[g*VEC_W +: VEC_W]  <= cfg_vec;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       dflt_q <= '1;
    else if (dflt_we) dflt_q <= dflt_vec;
  end
endmodule

// File: rtl/evsched_arb.sv
module evsched_arb
  import evsched_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       pend,
  input  logic [N*IDX_W-1:0] prio_flat,
  output logic [N-1:0]       win_oh,
  output logic [IDX_W-1:0]   win_idx,
  output logic               win_any
);
  logic [IDX_W-1:0] best_prio;

  always_comb begin
    win_any   = 1'b0;
    win_idx   = '0;
    best_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && more_urgent(win_any, 32'(prio_flat[i*IDX_W +: IDX_W]),
                                 32'(best_prio))) begin
        win_any   = 1'b1;
        win_idx   = IDX_W'(i);
        best_prio = prio_flat[i*IDX_W +: IDX_W];
      end
    end
    win_oh = '0;
    if (win_any) win_oh[win_idx] = 1'b1;
  end
endmodule

// File: rtl/evsched_flags.sv
module evsched_flags #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_pulse,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] take,
  output logic [N-1:0] pend,
  output logic [N-1:0] ovr
);
  logic [N-1:0] pend_d, ovr_d, merged;

  // a pulse landing on a flag that stays set is a lost (merged) event
  assign merged = ev_pulse & pend & ~take;
  assign pend_d = (pend & ~take & ~clr_mask) | ev_pulse;
  assign ovr_d  = (ovr & ~clr_mask) | merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      ovr  <= '0;
    end else begin
      pend <= pend_d;
      ovr  <= ovr_d;
    end
  end
endmodule

// File: rtl/evsched_top.sv
module evsched_top
  import evsched_pkg::*;
#(
  parameter int unsigned N     = DEF_TASKS,
  parameter int unsigned VEC_W = DEF_VEC_W,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ev_pulse,
  input  logic [N-1:0]     clr_mask,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [IDX_W-1:0] cfg_prio,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic             dflt_we,
  input  logic [VEC_W-1:0] dflt_vec,
  input  logic             dispatch,
  output logic             disp_ack,
  output logic             disp_valid,
  output logic [VEC_W-1:0] disp_vec,
  output logic [IDX_W-1:0] disp_task,
  output logic [N-1:0]     pend,
  output logic [N-1:0]     ovr
);
  logic [N*IDX_W-1:0] prio_flat;
  logic [N*VEC_W-1:0] vec_flat;
  logic [VEC_W-1:0]   dflt_q;
  logic [N-1:0]       win_oh;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;
  logic [N-1:0]       take;
  logic [VEC_W-1:0]   win_vec;

  evsched_cfg #(.N(N), .VEC_W(VEC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_prio(cfg_prio), .cfg_vec(cfg_vec), .dflt_we(dflt_we),
    .dflt_vec(dflt_vec), .prio_flat(prio_flat), .vec_flat(vec_flat),
    .dflt_q(dflt_q)
  );

  evsched_arb #(.N(N)) u_arb (
    .pend(pend), .prio_flat(prio_flat), .win_oh(win_oh),
    .win_idx(win_idx), .win_any(win_any)
  );

  assign take    = dispatch ? win_oh : '0;
  assign win_vec = vec_flat[win_idx*VEC_W +: VEC_W];

  evsched_flags #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .clr_mask(clr_mask),
    .take(take), .pend(pend), .ovr(ovr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_ack   <= 1'b0;
      disp_valid <= 1'b0;
      disp_vec   <= '0;
      disp_task  <= '0;
    end else begin
      disp_ack <= dispatch;
      if (dispatch) begin
        disp_valid <= win_any;
        disp_vec   <= win_any ? win_vec : dflt_q;
        disp_task  <= win_any ? win_idx : '0;
      end
    end
  end
endmodule

// File: rtl/evsched_chk.sv
module evsched_chk #(
  parameter int unsigned N     = 8,
  parameter int unsigned VEC_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     ev_pulse,
  input logic [N-1:0]     clr_mask,
  input logic             dispatch,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     ovr,
  input logic             disp_ack,
  input logic             disp_valid,
  input logic [VEC_W-1:0] disp_vec,
  input logic [N-1:0]     win_oh,
  input logic             win_any
);
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse != '0) |=> ((pend & $past(ev_pulse)) == $past(ev_pulse)));

  p_ack_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> disp_ack);

  p_no_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dispatch |=> !disp_ack);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dispatch |=> ($stable(disp_vec) && $stable(disp_valid)));

  p_valid_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> (disp_valid == ($past(pend) != '0)));

  p_single_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh) && (win_any == (pend != '0)));

  p_winner_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && win_any) |=> ((pend & $past(win_oh & ~ev_pulse)) == '0));

  p_empty_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch && !win_any) |=> !disp_valid);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((ovr & $past(ovr)) == $past(ovr)));
endmodule

bind evsched_top evsched_chk #(.N(N), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .clr_mask(clr_mask),
  .dispatch(dispatch), .pend(pend), .ovr(ovr), .disp_ack(disp_ack),
  .disp_valid(disp_valid), .disp_vec(disp_vec), .win_oh(win_oh),
  .win_any(win_any)
);

// File: tb/evsched_top_test.sv
module evsched_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int VEC_W = 10;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N-1:0]     ev_pulse, clr_mask;
  logic             cfg_we, dflt_we, dispatch;
  logic [IDX_W-1:0] cfg_idx, cfg_prio;
  logic [VEC_W-1:0] cfg_vec, dflt_vec;
  logic             disp_ack, disp_valid;
  logic [VEC_W-1:0] disp_vec;
  logic [IDX_W-1:0] disp_task;
  logic [N-1:0]     pend, ovr;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int bprio[N];
  int bvec[N];
  int bdflt;

  always #(CLK_PERIOD/2) clk = ~clk;

  evsched_top #(.N(N), .VEC_W(VEC_W)) uut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .clr_mask(clr_mask),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_vec(cfg_vec),
    .dflt_we(dflt_we), .dflt_vec(dflt_vec), .dispatch(dispatch),
    .disp_ack(disp_ack), .disp_valid(disp_valid), .disp_vec(disp_vec),
    .disp_task(disp_task), .pend(pend), .ovr(ovr)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // winner: scan priority levels from most urgent, slots ascending
  function automatic int expect_task(logic [N-1:0] pat);
    for (int p = 0; p < N; p++)
      for (int t = 0; t < N; t++)
        if (pat[t] && bprio[t] == p) return t;
    return -1;
  endfunction

  task automatic cfg_write(int idx, int pr, int vc);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_prio = IDX_W'(pr); cfg_vec = VEC_W'(vc);
    tick();
    cfg_we = 0;
    bprio[idx] = pr; bvec[idx] = vc;
  endtask

  task automatic clear_all();
    clr_mask = '1; tick(); clr_mask = '0;
  endtask

  task automatic do_dispatch(logic [N-1:0] same_cycle_ev);
    dispatch = 1; ev_pulse = same_cycle_ev; tick(); dispatch = 0; ev_pulse = '0;
  endtask

  task automatic run_pattern(logic [N-1:0] pat);
    int w;
    int vec_before;
    vec_before = int'(disp_vec);
    ev_pulse = pat; tick(); ev_pulse = '0;
    chk("R2 pend after pulse", int'(pend), int'(pat));
    chk("R3 no ack without dispatch", int'(disp_ack), 0);
    chk("R3 vector held", int'(disp_vec), vec_before);
    do_dispatch('0);
    w = expect_task(pat);
    chk("R4 ack", int'(disp_ack), 1);
    if (w < 0) begin
      chk("R7 valid low", int'(disp_valid), 0);
      chk("R7 default vector", int'(disp_vec), bdflt);
      chk("R7 task zero", int'(disp_task), 0);
      chk("R5 pend unchanged", int'(pend), 0);
    end else begin
      chk("R4 valid", int'(disp_valid), 1);
      chk("R4 vector", int'(disp_vec), bvec[w]);
      chk("R4 task", int'(disp_task), w);
      chk("R5 winner cleared", int'(pend), int'(pat & ~(N'(1) << w)));
    end
    clear_all();
  endtask

  initial begin
    rst_n = 0; ev_pulse = '0; clr_mask = '0; cfg_we = 0; dflt_we = 0;
    dispatch = 0; cfg_idx = '0; cfg_prio = '0; cfg_vec = '0; dflt_vec = '0;
    for (int i = 0; i < N; i++) begin bprio[i] = i; bvec[i] = i; end
    bdflt = 'h3FF;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 pend reset", int'(pend), 0);
    chk("R1 ovr reset", int'(ovr), 0);
    chk("R1 ack reset", int'(disp_ack), 0);
    chk("R1 valid reset", int'(disp_valid), 0);

    do_dispatch('0);
    chk("R7 empty valid", int'(disp_valid), 0);
    chk("R1 R7 default vector reset", int'(disp_vec), 'h3FF);

    // reset priorities: slot index order
    run_pattern(8'hFF);
    run_pattern(8'hA0);

    // sweep A: reversed priorities
    for (int i = 0; i < N; i++) cfg_write(i, N-1-i, (i*37 + 100) & 'h3FF);
    dflt_vec = 10'h155; dflt_we = 1; tick(); dflt_we = 0; bdflt = 'h155;
    for (int p = 0; p < 256; p++) run_pattern(8'(p));
    // sweep B: permutation 3i+5 mod 8 (R10 reconfiguration)
    for (int i = 0; i < N; i++) cfg_write(i, (3*i + 5) % N, (i*91 + 7) & 'h3FF);
    for (int p = 0; p < 256; p++) run_pattern(8'(p));

    // R6: event to winner in the dispatch cycle
    ev_pulse = 8'h12; tick(); ev_pulse = '0;
    begin
      int w;
      w = expect_task(8'h12);
      do_dispatch(N'(1) << w);
      chk("R6 vector", int'(disp_vec), bvec[w]);
      chk("R6 flag kept", int'(pend), 'h12);
      chk("R6 no overrun", int'(ovr), 0);
    end
    clear_all();

    // R8: repeated pulse merges, sets sticky overrun
    ev_pulse = 8'h10; tick(); tick(); ev_pulse = '0;
    chk("R8 merged pend", int'(pend), 'h10);
    chk("R8 overrun set", int'(ovr), 'h10);
    do_dispatch('0);
    chk("R8 dispatched vector", int'(disp_vec), bvec[4]);
    chk("R8 pend cleared", int'(pend), 0);
    chk("R8 overrun sticky", int'(ovr), 'h10);
    clr_mask = 8'h10; tick(); clr_mask = '0;
    chk("R9 overrun cleared", int'(ovr), 0);

    // R9: clear mask, and set-over-clear precedence
    ev_pulse = 8'h41; tick(); ev_pulse = '0;
    clr_mask = 8'h01; tick(); clr_mask = '0;
    chk("R9 w1c pend", int'(pend), 'h40);
    clr_mask = 8'h40; ev_pulse = 8'h40; tick(); clr_mask = '0; ev_pulse = '0;
    chk("R9 event beats clear", int'(pend & 8'h40), 'h40);
    clear_all();

    // R10: single write moves slot 7 to the top
    cfg_write(7, 0, 'h2AB);
    cfg_write(0, 1, 'h111);
    ev_pulse = 8'h81; tick(); ev_pulse = '0;
    do_dispatch('0);
    chk("R10 new priority wins", int'(disp_task), 7);
    chk("R10 new vector", int'(disp_vec), 'h2AB);
    clear_all();

    // R11: equal priorities, lower index wins
    cfg_write(2, 6, 'h022);
    cfg_write(5, 6, 'h055);
    ev_pulse = 8'h24; tick(); ev_pulse = '0;
    do_dispatch('0);
    chk("R11 tie task", int'(disp_task), 2);
    chk("R11 tie vector", int'(disp_vec), 'h022);
    do_dispatch('0);
    chk("R11 second", int'(disp_task), 5);
    clear_all();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule